// File: doc/BRIEF.md
# Synchronous Burst Memory Cycle Decoder

This block sits in front of a synchronous burst static memory and sorts every rising clock edge into one kind of access. It samples two address strobes, a burst advance input, three chip enables (two active low, one active high), four per-byte write enables, a byte-write qualifier and a global write input. From them it decides whether the edge loads a fresh external address, steps the burst onward, holds the burst in place, or deselects the part. It also decides whether any byte is written.

The processor-side strobe always starts a read and is only honoured while the first chip enable is low. The controller-side strobe may start either a read or a write and needs all three enables active. When neither strobe starts a cycle, the advance input picks between continuing and suspending the current burst. An internal active flag makes sure that continue and suspend requests made while the part is deselected turn into no access. All results are registered and appear one clock after the sampling edge as a load strobe, an advance strobe, a byte write mask, a deselect flag and a one-hot cycle-kind vector.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high and after it, before any other edge, cyc_o is 7'b0000001 (deselect), desel_o is 1, and load_o, adv_o and wmask_o are 0.
- R2: Byte mask decode: gw_n_i low gives all four bytes. With gw_n_i high and bwe_n_i high no byte is written. With gw_n_i high and bwe_n_i low, mask bit i is set exactly when bw_n_i[i] is low. Mask bit i covers data bits 8*i+7 down to 8*i. A cycle counts as a write when this mask is nonzero.
- R3: With adsp_n_i low and ce_n_i low, and ce2_n_i low and ce2_i high, the edge is a begin-burst read (cyc_o bit 1): load_o is 1 and wmask_o is 0, whatever adsc_n_i, gw_n_i, bwe_n_i and bw_n_i show.
- R4: With adsp_n_i low and ce_n_i low, and ce2_n_i high or ce2_i low, the edge is a deselect (cyc_o bit 0) and the active flag clears.
- R5: With ce_n_i high, adsp_n_i has no effect: the result equals the one given with adsp_n_i high.
- R6: When the processor strobe is not accepted, adsc_n_i is low and all chip enables are active, the edge is a begin-burst write (cyc_o bit 2, wmask_o = decoded mask) when the mask is nonzero, or a begin-burst read (bit 1) otherwise. load_o is 1 and the active flag sets.
- R7: When the processor strobe is not accepted, adsc_n_i is low and any chip enable is inactive, the edge is a deselect with load_o 0.
- R8: When no strobe starts a cycle and the part is active, chip enables are ignored. adv_n_i low gives continue (read bit 3, write bit 4, adv_o 1) and adv_n_i high gives suspend (read bit 5, write bit 6, adv_o 0). load_o is 0, and wmask_o is the mask on writes and 0 on reads.
- R9: When no strobe starts a cycle and the part is deselected, the edge is a deselect with load_o, adv_o and wmask_o all 0.
- R10: Outputs change only on the rising edge that samples the inputs. cyc_o is always one-hot, desel_o equals cyc_o bit 0, load_o is set only for begin kinds, and adv_o is set only for continue kinds.
- R11: On the edge after a processor-strobe load, both strobes high, adv_n_i high and byte enables low give a suspend write (bit 6) with load_o 0 and adv_o 0, so the write lands on the address just loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_n_i | input | 1 | Expansion chip enable, active low |
| ce2_i | input | 1 | Expansion chip enable, active high |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write qualifier, active low |
| bw_n_i | input | 4 | Per-byte write enables, active low |
| load_o | output | 1 | New external address loaded |
| adv_o | output | 1 | Burst address steps on |
| wmask_o | output | 4 | Registered byte write mask |
| desel_o | output | 1 | Deselect cycle |
| cyc_o | output | 7 | One-hot cycle kind, bit 0 deselect to bit 6 suspend write |

## Verification
The sharpest overlap comes when both address strobes are low on the same edge. The processor strobe wants a read, while the controller strobe, given active byte enables, wants a write. The outcome then hinges on the primary chip enable alone: it either hands the edge to the read path or makes the processor strobe void. The bench drives every combination of strobes, enables, advance and write inputs. It does this once from an active state and once from a deselected state, and compares the full registered output against a truth-table model. A mismatch on any of these contested edges shows up as a wrong cycle kind or a wrong mask.

// File: rtl/sram_cc_pkg.sv
package sram_cc_pkg;

  typedef enum logic [2:0] {
    CY_DESEL    = 3'd0,
    CY_RD_BEGIN = 3'd1,
    CY_WR_BEGIN = 3'd2,
    CY_RD_CONT  = 3'd3,
    CY_WR_CONT  = 3'd4,
    CY_RD_SUSP  = 3'd5,
    CY_WR_SUSP  = 3'd6
  } cyc_kind_e;

  localparam int CYC_KINDS = 7;

  typedef struct packed {
    logic adsp_n;
    logic adsc_n;
    logic adv_n;
    logic en_a_n;
    logic en_b_n;
    logic en_c;
  } strobe_t;

endpackage

// File: rtl/sram_cc_wmask.sv
module sram_cc_wmask #(
  parameter int NBYTES = 4
) (
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bw_n,
  output logic [NBYTES-1:0] mask,
  output logic              any_wr
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign mask[b] = !gw_n || (!bwe_n && !bw_n[b]);
  end

  assign any_wr = |mask;

endmodule

// File: rtl/sram_cc_classify.sv
module sram_cc_classify
  import sram_cc_pkg::*;
(
  input  strobe_t   st,
  input  logic      any_wr,
  input  logic      active,
  output cyc_kind_e kind
);

  logic proc_take;
  logic chips_ok;

  assign proc_take = !st.adsp_n && !st.en_a_n;
  assign chips_ok  = !st.en_a_n && !st.en_b_n && st.en_c;

  always_comb begin
    if (proc_take) begin
      kind = chips_ok ? CY_RD_BEGIN : CY_DESEL;
    end else if (!st.adsc_n) begin
      if (!chips_ok)   kind = CY_DESEL;
      else if (any_wr) kind = CY_WR_BEGIN;
      else             kind = CY_RD_BEGIN;
    end else if (!active) begin
      kind = CY_DESEL;
    end else if (!st.adv_n) begin
      kind = any_wr ? CY_WR_CONT : CY_RD_CONT;
    end else begin
      kind = any_wr ? CY_WR_SUSP : CY_RD_SUSP;
    end
  end

endmodule

// File: rtl/sram_cc_state.sv
module sram_cc_state
  import sram_cc_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cyc_kind_e            kind,
  input  logic [NBYTES-1:0]    mask_in,
  output logic                 active_o,
  output logic                 load_o,
  output logic                 adv_o,
  output logic [NBYTES-1:0]    wmask_o,
  output logic                 desel_o,
  output logic [CYC_KINDS-1:0] cyc_o
);

  logic [CYC_KINDS-1:0] onehot_d;
  logic                 is_begin;
  logic                 is_cont;
  logic                 is_write;
  logic                 active_q;
  logic                 load_q;
  logic                 adv_q;
  logic [NBYTES-1:0]    wmask_q;
  logic [CYC_KINDS-1:0] cyc_q;

  for (genvar k = 0; k < CYC_KINDS; k++) begin : g_kind
    assign onehot_d[k] = (kind == cyc_kind_e'(k));
  end

  assign is_begin = (kind == CY_RD_BEGIN) || (kind == CY_WR_BEGIN);
  assign is_cont  = (kind == CY_RD_CONT)  || (kind == CY_WR_CONT);
  assign is_write = (kind == CY_WR_BEGIN) || (kind == CY_WR_CONT) ||
                    (kind == CY_WR_SUSP);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      load_q   <= 1'b0;
      adv_q    <= 1'b0;
      wmask_q  <= '0;
      cyc_q    <= CYC_KINDS'(1);
    end else begin
      if (is_begin)              active_q <= 1'b1;
      else if (kind == CY_DESEL) active_q <= 1'b0;
      load_q  <= is_begin;
      adv_q   <= is_cont;
      wmask_q <= is_write ? mask_in : '0;
      cyc_q   <= onehot_d;
    end
  end

  assign active_o = active_q;
  assign load_o   = load_q;
  assign adv_o    = adv_q;
  assign wmask_o  = wmask_q;
  assign desel_o  = cyc_q[0];
  assign cyc_o    = cyc_q;

  assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot(cyc_q));

  assert_load_sets_active_R6: assert property (@(posedge clk) disable iff (rst)
    load_q |-> active_q);

  assert_desel_drops_R4: assert property (@(posedge clk) disable iff (rst)
    cyc_q[0] |-> !active_q);

  assert_adv_cont_only_R10: assert property (@(posedge clk) disable iff (rst)
    adv_q |-> (cyc_q[3] || cyc_q[4]));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_cc_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adsp_n_i,
  input  logic                 adsc_n_i,
  input  logic                 adv_n_i,
  input  logic                 ce_n_i,
  input  logic                 ce2_n_i,
  input  logic                 ce2_i,
  input  logic                 gw_n_i,
  input  logic                 bwe_n_i,
  input  logic [NBYTES-1:0]    bw_n_i,
  output logic                 load_o,
  output logic                 adv_o,
  output logic [NBYTES-1:0]    wmask_o,
  output logic                 desel_o,
  output logic [CYC_KINDS-1:0] cyc_o
);

  strobe_t           st;
  logic [NBYTES-1:0] mask;
  logic              any_wr;
  logic              active;
  cyc_kind_e         kind;

  assign st = '{adsp_n: adsp_n_i, adsc_n: adsc_n_i, adv_n: adv_n_i,
                en_a_n: ce_n_i, en_b_n: ce2_n_i, en_c: ce2_i};

  sram_cc_wmask #(.NBYTES(NBYTES)) u_wmask (
    .gw_n   (gw_n_i),
    .bwe_n  (bwe_n_i),
    .bw_n   (bw_n_i),
    .mask   (mask),
    .any_wr (any_wr)
  );

  sram_cc_classify u_classify (
    .st     (st),
    .any_wr (any_wr),
    .active (active),
    .kind   (kind)
  );

  sram_cc_state #(.NBYTES(NBYTES)) u_state (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .mask_in  (mask),
    .active_o (active),
    .load_o   (load_o),
    .adv_o    (adv_o),
    .wmask_o  (wmask_o),
    .desel_o  (desel_o),
    .cyc_o    (cyc_o)
  );

  assert_mask_readonly_R2: assert property (@(posedge clk) disable iff (rst)
    (gw_n_i && bwe_n_i) |=> (wmask_o == '0));

  assert_proc_read_R3: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n_i && !ce_n_i) |=> (!cyc_o[2] && !cyc_o[4] && !cyc_o[6] && wmask_o == '0));

  assert_ctrl_desel_R7: assert property (@(posedge clk) disable iff (rst)
    ((adsp_n_i || ce_n_i) && !adsc_n_i && (ce_n_i || ce2_n_i || !ce2_i))
      |=> (desel_o && !load_o));

  assert_cont_adv_R8: assert property (@(posedge clk) disable iff (rst)
    (active && (adsp_n_i || ce_n_i) && adsc_n_i && !adv_n_i) |=> (adv_o && !load_o));

  assert_idle_noaccess_R9: assert property (@(posedge clk) disable iff (rst)
    (!active && (adsp_n_i || ce_n_i) && adsc_n_i)
      |=> (desel_o && !adv_o && wmask_o == '0));

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adsp_n_i, adsc_n_i, adv_n_i, ce_n_i, ce2_n_i, ce2_i, gw_n_i, bwe_n_i;
  logic [3:0] bw_n_i;
  logic       load_o, adv_o, desel_o;
  logic [3:0] wmask_o;
  logic [6:0] cyc_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  sram_cycle_ctrl u_dut (
    .clk(clk), .rst(rst),
    .adsp_n_i(adsp_n_i), .adsc_n_i(adsc_n_i), .adv_n_i(adv_n_i),
    .ce_n_i(ce_n_i), .ce2_n_i(ce2_n_i), .ce2_i(ce2_i),
    .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .bw_n_i(bw_n_i),
    .load_o(load_o), .adv_o(adv_o), .wmask_o(wmask_o),
    .desel_o(desel_o), .cyc_o(cyc_o)
  );

  // vector: [11]adsp_n [10]adsc_n [9]adv_n [8]ce_n [7]ce2_n [6]ce2
  //         [5]gw_n [4]bwe_n [3:0]bw_n
  localparam logic [11:0] V_CTRL_RD = 12'b1_0_1_0_0_1_1_1_1111;
  localparam logic [11:0] V_DESEL   = 12'b1_0_1_1_0_1_1_1_1111;
  localparam logic [11:0] V_PROC_RD = 12'b0_1_1_0_0_1_1_1_1111;
  localparam logic [11:0] V_SUSP_WR = 12'b1_1_1_1_1_0_1_0_0000;

  function automatic logic [13:0] pack_obs();
    return {cyc_o, load_o, adv_o, wmask_o, desel_o};
  endfunction

  // Truth-table model: returns {cyc(7), load, adv, mask(4), desel}
  function automatic logic [13:0] model(input logic [11:0] v, input logic act,
                                        output logic nact, output string tag);
    logic [3:0] m;
    int k;
    logic proc_ok, chips;
    m = v[5] ? (v[4] ? 4'b0000 : ~v[3:0]) : 4'b1111;
    proc_ok = !v[11] && !v[8];
    chips = !v[8] && !v[7] && v[6];
    nact = act;
    if (proc_ok) begin
      k = chips ? 1 : 0; tag = chips ? "R3" : "R4";
    end else if (!v[10]) begin
      k = !chips ? 0 : (m != 0 ? 2 : 1); tag = chips ? "R6" : "R7";
    end else if (!act) begin
      k = 0; tag = "R9";
    end else begin
      k = (!v[9] ? 3 : 5) + (m != 0 ? 1 : 0); tag = "R8";
    end
    if (!v[11] && v[8]) tag = "R5";
    if (k == 1 || k == 2) nact = 1'b1;
    if (k == 0) nact = 1'b0;
    return {7'(1 << k), (k == 1 || k == 2), (k == 3 || k == 4),
            ((k == 2 || k == 4 || k == 6) ? m : 4'b0000), (k == 0)};
  endfunction

  task automatic drive(input logic [11:0] v);
    {adsp_n_i, adsc_n_i, adv_n_i, ce_n_i, ce2_n_i, ce2_i, gw_n_i, bwe_n_i, bw_n_i} = v;
  endtask

  task automatic step(input logic [11:0] v);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic       na;
    string      tg;
    logic [13:0] e;
    drive(V_DESEL);
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", pack_obs(), 14'b0000001_0_0_0000_1);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 after reset", pack_obs(), 14'b0000001_0_0_0000_1);

    // R2 directed mask decode via controller strobe
    step(12'b1_0_1_0_0_1_0_1_1111);
    check("R2 global", pack_obs(), 14'b0000100_1_0_1111_0);
    step(12'b1_0_1_0_0_1_1_0_1010);
    check("R2 per-byte", pack_obs(), 14'b0000100_1_0_0101_0);
    step(12'b1_0_1_0_0_1_1_1_0000);
    check("R2 qualifier high", pack_obs(), 14'b0000010_1_0_0000_0);

    // R11 write after processor load
    step(V_PROC_RD);
    check("R11 proc load", pack_obs(), 14'b0000010_1_0_0000_0);
    step(V_SUSP_WR);
    check("R11 suspend write", pack_obs(), 14'b1000000_0_0_1111_0);

    // R10 outputs hold until the sampling edge
    step(V_CTRL_RD);
    @(negedge clk);
    drive(V_DESEL);
    #1;
    check("R10 before edge", pack_obs(), 14'b0000010_1_0_0000_0);
    @(posedge clk);
    #1;
    check("R10 after edge", pack_obs(), 14'b0000001_0_0_0000_1);

    // Exhaustive sweep from both states (R3..R9)
    for (int pre = 0; pre < 2; pre++) begin
      for (int v = 0; v < 4096; v++) begin
        step(pre ? V_CTRL_RD : V_DESEL);
        step(12'(v));
        e = model(12'(v), pre[0], na, tg);
        check(tg, pack_obs(), e);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule